// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether an I/O port access of one, two or four bytes may go ahead or must raise a general-protection fault. It is started with the processor context of the access: the protected-mode flag, the virtual-8086 flag, the current privilege level and the 2-bit I/O privilege level. It also receives the task segment's base, limit and type flags, and the port number and access size. Two cases are settled on the spot: when the processor is not in protected mode, and when the privilege level alone permits the access. In every other case the block first validates the task segment. It then reads a 16-bit bitmap displacement stored inside the task segment, and after that one or two bitmap bytes. All of these reads go through a simple byte/halfword read port and are marked as supervisor accesses.

The caller raises a start pulse and later gets a one-cycle done pulse that carries exactly one of allow or fault. Splitting misaligned port accesses into smaller pieces is handled outside this block. The block only ever sees a single access, whose permission bits may still straddle a bitmap byte boundary.

Top module: `io_perm_checker`

## Requirements
- R1: With the protected-mode flag low when start is taken, done_o rises in the next cycle with allow_o high, and no memory read is issued.
- R2: In protected mode with the virtual-8086 flag low and cpl_i <= iopl_i, done_o rises in the next cycle with allow_o high and no read. In virtual-8086 mode this shortcut never applies, whatever the privilege levels are.
- R3: When the shortcut does not apply, a task limit below 0x67, or type flags that give a value other than 4'h9 when ANDed with 4'hD, yields fault_o in the next cycle with no read. For example, type 4'hB passes this check and type 4'h1 fails it.
- R4: The first read is a halfword (mem_half_o high) at base + 0x66, with byte 0x66 as the low byte. Every read has mem_super_o high.
- R5: When the halfword displacement plus port/8 (the byte index) is greater than the task limit, the result is a fault and no bitmap byte is read. An index equal to the limit is accepted.
- R6: The bitmap byte is read as a byte (mem_half_o low) at base + index. The access faults when any bit from position port%8 upward, over 1, 2 or 4 bits for size codes 0, 1 and 2 (code 3 is treated as 4 bytes), is set; otherwise it is allowed.
- R7: When port%8 plus the access width exceeds 8 and the first byte has no set bit in range, the byte at base + index + 1 is also read, after checking index + 1 against the limit (greater faults with no read). Its low bits complete the window.
- R8: done_o lasts one cycle, carries exactly one of allow_o and fault_o, and start_i is ignored while busy_o is high.
- R9: A read request holds its address and size stable until mem_ack_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check, taken only when idle |
| port_i | input | PORT_W | I/O port number |
| size_i | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| prot_en_i | input | 1 | Protected mode active |
| v86_i | input | 1 | Virtual-8086 mode active |
| cpl_i | input | 2 | Current privilege level |
| iopl_i | input | 2 | I/O privilege level |
| tss_base_i | input | ADDR_W | Task segment linear base |
| tss_limit_i | input | ADDR_W | Task segment limit |
| tss_type_i | input | 4 | Task segment type flags |
| mem_req_o | output | 1 | Read request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Read address |
| mem_half_o | output | 1 | 1 = halfword read, 0 = byte read |
| mem_super_o | output | 1 | Read is a supervisor access |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_data_i | input | 16 | Read data; byte reads use bits 7:0 |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle result strobe |
| allow_o | output | 1 | Access permitted (valid with done_o) |
| fault_o | output | 1 | General-protection fault (valid with done_o) |

## Verification
The hardest case to reach is the second bitmap fetch. It needs a wide access whose bit offset sits near the top of a byte, a clear first byte over the in-range bits, and a limit that lands exactly on or just below the following index. The bench places a controlled displacement and bitmap bytes in its memory model and steers the limit to sit within a few bytes of the computed index, so that every ending of the walk occurs. Random traffic, with ports pushed to offsets 5 to 7, then mixes these endings with varying acknowledge delays.

// File: rtl/iop_pkg.sv
package iop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_OFS,
        ST_READ_MAP,
        ST_READ_MAP2,
        ST_DONE
    } iop_state_e;

    typedef enum logic [1:0] {
        PRE_ALLOW,
        PRE_FAULT,
        PRE_WALK
    } iop_pre_e;

    // Layout constants of the task segment
    localparam logic [11:0] BITMAP_PTR_DISP = 12'h066;
    localparam logic [11:0] TSS_MIN_LIMIT   = 12'h067;
    localparam logic [3:0]  TYPE_SEL_MASK   = 4'hD;
    localparam logic [3:0]  TYPE_SEL_MATCH  = 4'h9;

    function automatic logic [3:0] size_to_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [3:0] size_to_width(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/iop_gate.sv
module iop_gate
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              prot_en,
    input  logic              v86,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    input  logic [ADDR_W-1:0] limit,
    input  logic [3:0]        seg_type,
    output iop_pre_e          verdict
);

    logic priv_ok;
    logic desc_ok;

    assign priv_ok = !v86 && (cpl <= iopl);
    assign desc_ok = (limit >= ADDR_W'(TSS_MIN_LIMIT)) &&
                     ((seg_type & TYPE_SEL_MASK) == TYPE_SEL_MATCH);

    always_comb begin
        if (!prot_en || priv_ok) verdict = PRE_ALLOW;
        else if (!desc_ok)       verdict = PRE_FAULT;
        else                     verdict = PRE_WALK;
    end

endmodule

// File: rtl/iop_map_eval.sv
module iop_map_eval
    import iop_pkg::*;
(
    input  logic [7:0] lo_byte,
    input  logic [7:0] hi_byte,
    input  logic [2:0] bit_ofs,
    input  logic [1:0] size,
    output logic       hit,
    output logic       spans
);

    logic [15:0] pair;
    logic [3:0]  window;

    assign pair   = {hi_byte, lo_byte};
    assign window = pair[bit_ofs +: 4];
    assign hit    = |(window & size_to_mask(size));
    assign spans  = ({1'b0, bit_ofs} + size_to_width(size)) > 4'd8;

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [1:0]        size_i,
    input  logic              prot_en_i,
    input  logic              v86_i,
    input  logic [1:0]        cpl_i,
    input  logic [1:0]        iopl_i,
    input  logic [ADDR_W-1:0] tss_base_i,
    input  logic [ADDR_W-1:0] tss_limit_i,
    input  logic [3:0]        tss_type_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_half_o,
    output logic              mem_super_o,
    input  logic              mem_ack_i,
    input  logic [15:0]       mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              allow_o,
    output logic              fault_o
);

    localparam int BYTE_IDX_W = PORT_W - 3;

    iop_state_e        state_q;
    logic [PORT_W-1:0] port_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [ADDR_W-1:0] idx_q;
    logic [7:0]        lo_q;
    logic              allow_q;

    iop_pre_e          pre_verdict;
    logic [ADDR_W-1:0] idx_calc;
    logic [ADDR_W-1:0] idx_next;
    logic [7:0]        eval_lo;
    logic [7:0]        eval_hi;
    logic              map_hit;
    logic              map_spans;

    iop_gate #(.ADDR_W(ADDR_W)) u_gate (
        .prot_en  (prot_en_i),
        .v86      (v86_i),
        .cpl      (cpl_i),
        .iopl     (iopl_i),
        .limit    (tss_limit_i),
        .seg_type (tss_type_i),
        .verdict  (pre_verdict)
    );

    // In the second fetch the stored first byte is the low half of the window
    assign eval_lo = (state_q == ST_READ_MAP2) ? lo_q : mem_data_i[7:0];
    assign eval_hi = (state_q == ST_READ_MAP2) ? mem_data_i[7:0] : 8'h00;

    iop_map_eval u_eval (
        .lo_byte (eval_lo),
        .hi_byte (eval_hi),
        .bit_ofs (port_q[2:0]),
        .size    (size_q),
        .hit     (map_hit),
        .spans   (map_spans)
    );

    assign idx_calc = ADDR_W'(mem_data_i) + ADDR_W'(port_q[PORT_W-1 -: BYTE_IDX_W]);
    assign idx_next = idx_q + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            size_q  <= '0;
            base_q  <= '0;
            limit_q <= '0;
            idx_q   <= '0;
            lo_q    <= '0;
            allow_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        port_q  <= port_i;
                        size_q  <= size_i;
                        base_q  <= tss_base_i;
                        limit_q <= tss_limit_i;
                        case (pre_verdict)
                            PRE_ALLOW: begin
                                allow_q <= 1'b1;
                                state_q <= ST_DONE;
                            end
                            PRE_FAULT: begin
                                allow_q <= 1'b0;
                                state_q <= ST_DONE;
                            end
                            default: state_q <= ST_READ_OFS;
                        endcase
                    end
                end
                ST_READ_OFS: begin
                    if (mem_ack_i) begin
                        idx_q <= idx_calc;
                        if (idx_calc > limit_q) begin
                            allow_q <= 1'b0;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_READ_MAP;
                        end
                    end
                end
                ST_READ_MAP: begin
                    if (mem_ack_i) begin
                        if (map_hit) begin
                            allow_q <= 1'b0;
                            state_q <= ST_DONE;
                        end else if (map_spans) begin
                            if (idx_next > limit_q) begin
                                allow_q <= 1'b0;
                                state_q <= ST_DONE;
                            end else begin
                                lo_q    <= mem_data_i[7:0];
                                state_q <= ST_READ_MAP2;
                            end
                        end else begin
                            allow_q <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_READ_MAP2: begin
                    if (mem_ack_i) begin
                        allow_q <= !map_hit;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            ST_READ_OFS:  mem_addr_o = base_q + ADDR_W'(BITMAP_PTR_DISP);
            ST_READ_MAP:  mem_addr_o = base_q + idx_q;
            ST_READ_MAP2: mem_addr_o = base_q + idx_next;
            default:      mem_addr_o = '0;
        endcase
    end

    assign mem_req_o   = (state_q == ST_READ_OFS) || (state_q == ST_READ_MAP) ||
                         (state_q == ST_READ_MAP2);
    assign mem_half_o  = (state_q == ST_READ_OFS);
    assign mem_super_o = mem_req_o;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign allow_o     = done_o && allow_q;
    assign fault_o     = done_o && !allow_q;

endmodule

// File: rtl/io_perm_checker_props.sv
module io_perm_checker_props #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              prot_en_i,
    input logic              v86_i,
    input logic [1:0]        cpl_i,
    input logic [1:0]        iopl_i,
    input logic [ADDR_W-1:0] tss_limit_i,
    input logic [3:0]        tss_type_i,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_half_o,
    input logic              mem_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              allow_o,
    input logic              fault_o
);

    logic take;
    logic no_bypass;
    logic bad_desc;

    assign take      = start_i && !busy_o;
    assign no_bypass = prot_en_i && (v86_i || (cpl_i > iopl_i));
    assign bad_desc  = (tss_limit_i < ADDR_W'(12'h067)) ||
                       ((tss_type_i & 4'hD) != 4'h9);

    assert_real_mode_allow_R1: assert property (@(posedge clk) disable iff (rst)
        take && !prot_en_i |=> done_o && allow_o && !mem_req_o);

    assert_priv_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        take && prot_en_i && !v86_i && (cpl_i <= iopl_i) |=> done_o && allow_o);

    assert_bad_desc_fault_R3: assert property (@(posedge clk) disable iff (rst)
        take && no_bypass && bad_desc |=> done_o && fault_o);

    assert_verdict_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (allow_o != fault_o) && !mem_req_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_half_o));

endmodule

bind io_perm_checker io_perm_checker_props #(.ADDR_W(ADDR_W)) u_props (.*);

// File: tb/io_perm_checker_bench.sv
module io_perm_checker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] port;
    logic [1:0]  size;
    logic        prot, v86;
    logic [1:0]  cpl, iopl;
    logic [31:0] base, limit;
    logic [3:0]  ttype;
    logic        mem_req, mem_half, mem_super;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [15:0] mem_data;
    logic        busy, done, allow, fault;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    int done_cnt = 0;
    int super_bad = 0;
    int wait_cnt = 0;
    int cycles = 0;
    logic [31:0] last_half_addr, last_byte_addr;
    logic [7:0]  mem_b [0:1023];

    always #4 clk = ~clk;

    io_perm_checker u_io_perm_checker (
        .clk(clk), .rst(rst), .start_i(start), .port_i(port), .size_i(size),
        .prot_en_i(prot), .v86_i(v86), .cpl_i(cpl), .iopl_i(iopl),
        .tss_base_i(base), .tss_limit_i(limit), .tss_type_i(ttype),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_half_o(mem_half),
        .mem_super_o(mem_super), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
        .busy_o(busy), .done_o(done), .allow_o(allow), .fault_o(fault)
    );

    // Memory responder: acknowledge after 0..2 idle cycles
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (!mem_super) super_bad++;
            if (wait_cnt == 0) begin
                if (mem_half) begin
                    mem_data = {mem_b[10'(mem_addr[9:0] + 10'd1)], mem_b[mem_addr[9:0]]};
                    last_half_addr = mem_addr;
                end else begin
                    mem_data = {8'h00, mem_b[mem_addr[9:0]]};
                    last_byte_addr = mem_addr;
                end
                rd_count++;
                mem_ack  = 1'b1;
                wait_cnt = int'($urandom_range(2, 0));
            end else begin
                wait_cnt--;
            end
        end
    end

    always @(negedge clk) if (done) done_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rd8(input int a);
        return int'(mem_b[a & 1023]);
    endfunction

    // Expected verdict and number of reads, from the requirements
    function automatic void model(output bit al, output int nr);
        int ofs, idx, w, sh, msk, first, both;
        nr = 0;
        if (!prot || (!v86 && cpl <= iopl)) begin al = 1; return; end
        if (limit < 32'h67 || (ttype & 4'hD) != 4'h9) begin al = 0; return; end
        ofs = rd8(int'(base) + 'h66) | (rd8(int'(base) + 'h67) << 8);
        nr = 1;
        idx = ofs + int'(port) / 8;
        if (idx > int'(limit)) begin al = 0; return; end
        nr = 2;
        w   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        sh  = int'(port) % 8;
        msk = (1 << w) - 1;
        first = (rd8(int'(base) + idx) >> sh) & msk;
        if (first != 0) begin al = 0; return; end
        if (sh + w <= 8) begin al = 1; return; end
        if (idx + 1 > int'(limit)) begin al = 0; return; end
        nr = 3;
        both = ((rd8(int'(base) + idx) | (rd8(int'(base) + idx + 1) << 8)) >> sh) & msk;
        al = (both == 0);
    endfunction

    task automatic run(input string req, input bit hold_start);
        bit exp_al;
        int exp_nr, rd0, dn0, n;
        model(exp_al, exp_nr);
        rd0 = rd_count;
        dn0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        start = 1'b0;
        chk(done == 1'b1, req, "done seen", int'(done), 1);
        chk(allow == exp_al && fault == !exp_al, req, "verdict allow", int'(allow), int'(exp_al));
        chk(rd_count - rd0 == exp_nr, req, "read count", rd_count - rd0, exp_nr);
        @(negedge clk);
        @(negedge clk);
        if (hold_start)
            chk(done_cnt - dn0 == 1 && !busy, "R8", "done pulses with start held", done_cnt - dn0, 1);
    endtask

    task automatic set_ofs(input int ofs);
        mem_b[(int'(base) + 'h66) & 1023] = 8'(ofs);
        mem_b[(int'(base) + 'h67) & 1023] = 8'(ofs >> 8);
    endtask

    task automatic walk_ctx;
        prot = 1; v86 = 0; cpl = 3; iopl = 0; ttype = 4'h9;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem_b[i] = 8'($urandom);
        rst = 1; start = 0; port = 0; size = 0; prot = 0; v86 = 0; cpl = 0; iopl = 0;
        base = 32'h40; limit = 32'h200; ttype = 4'h9; mem_ack = 0; mem_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!done && !busy && !mem_req && !allow && !fault, "R8", "reset idle", int'(busy), 0);

        // R1: real mode
        prot = 0; v86 = 1; cpl = 3; iopl = 0; limit = 0;
        run("R1", 0);

        // R2: privilege bypass and its absence in virtual-8086 mode
        prot = 1; v86 = 0; cpl = 1; iopl = 2; limit = 0; ttype = 0;
        run("R2", 0);
        cpl = 3; iopl = 3;
        run("R2", 0);
        v86 = 1; cpl = 0; iopl = 3; limit = 32'h200; ttype = 4'h9;
        set_ofs('h80); port = 16'd80; size = 0;
        mem_b[(int'(base) + 'h80 + 10) & 1023] = 8'h01;
        run("R2", 0);

        // R3: descriptor checks
        walk_ctx(); limit = 32'h66;
        run("R3", 0);
        limit = 32'h67; ttype = 4'h1;
        run("R3", 0);
        ttype = 4'hB; limit = 32'h200;
        run("R3", 0);

        // R5: index against limit
        walk_ctx(); set_ofs('h80); port = 16'd128; size = 0;
        limit = 32'h90;
        run("R5", 0);
        limit = 32'h8F;
        run("R5", 0);

        // R6: size masks, with bit 4 set in the map byte
        walk_ctx(); limit = 32'h200; set_ofs('h80);
        mem_b[(int'(base) + 'h80) & 1023] = 8'b0001_0000;
        port = 16'd4; size = 0; run("R6", 0);
        port = 16'd3; size = 0; run("R6", 0);
        port = 16'd1; size = 2; run("R6", 0);
        port = 16'd2; size = 1; run("R6", 0);
        chk(last_half_addr == base + 32'h66, "R4", "displacement address", int'(last_half_addr), int'(base + 32'h66));
        chk(last_byte_addr == base + 32'h80, "R6", "bitmap byte address", int'(last_byte_addr), int'(base + 32'h80));

        // R7: window crossing into the next byte
        mem_b[(int'(base) + 'h80) & 1023] = 8'h00;
        mem_b[(int'(base) + 'h81) & 1023] = 8'h01;
        port = 16'd6; size = 2; run("R7", 0);
        chk(last_byte_addr == base + 32'h81, "R7", "second byte address", int'(last_byte_addr), int'(base + 32'h81));
        port = 16'd6; size = 1; run("R7", 0);
        port = 16'd7; size = 1; limit = 32'h80; run("R7", 0);
        mem_b[(int'(base) + 'h81) & 1023] = 8'hF8;
        port = 16'd5; size = 2; limit = 32'h81; run("R7", 0);

        // R8: start held while busy
        walk_ctx(); limit = 32'h200; port = 16'd12; size = 0;
        run("R8", 1);

        // Random traffic
        for (int k = 0; k < 300; k++) begin
            int ofs, idx;
            prot  = ($urandom_range(9, 0) != 0);
            v86   = ($urandom_range(3, 0) == 0);
            cpl   = 2'($urandom);
            iopl  = 2'($urandom);
            ttype = ($urandom_range(5, 0) == 0) ? 4'($urandom) : 4'h9;
            port  = 16'($urandom_range(2047, 0));
            if ($urandom_range(1, 0) == 1) port[2:0] = 3'(5 + $urandom_range(2, 0));
            size  = 2'($urandom);
            ofs   = int'($urandom_range(32'h100, 32'h68));
            set_ofs(ofs);
            idx   = ofs + int'(port) / 8;
            if ($urandom_range(7, 0) == 0) begin
                mem_b[(int'(base) + idx) & 1023]     = 8'h00;
                mem_b[(int'(base) + idx + 1) & 1023] = 8'($urandom);
            end
            limit = 32'(idx + int'($urandom_range(3, 0)) - 1);
            if ($urandom_range(9, 0) == 0) limit = 32'($urandom_range(32'h70, 32'h60));
            run("R6", k % 17 == 0);
        end

        chk(super_bad == 0, "R4", "non-supervisor reads", super_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule